// File: doc/BRIEF.md
# Compound-Adder Significand Rounding Unit

This block adds or subtracts two aligned significands of `SIG_W` bits and delivers the correctly rounded result in one pass. It has no separate increment stage after the adder. A single carry-propagate sum `X = A + B'` is formed, with `B'` equal to `B` for addition and `~B` for subtraction. Two further candidates, `X+1` and `X+2`, are derived from `X` by parallel trailing-ones prefix logic.

The rounding logic only chooses between two of the three candidates. For addition the choice is between the truncated value `X` and its increment `X+1`. For subtraction it is between `X+1`, which equals `A-B`, and `X+2`, which equals `A-B+1`. The choice depends on the rounding mode, the result sign, the least significant bit of the truncated value, and the guard, round and sticky bits.

The caller supplies the guard, round and sticky bits as the exact fraction lying below the LSB of the truncated result. For subtraction the caller must present the larger magnitude on `op_a`. Operand alignment, leading-zero handling and the exponent are handled outside the block. Outputs are registered: a result appears one clock after its inputs.

Top module: `sig_round_unit`

## Requirements
- R1: With `eff_sub`=0, `{carry_out, sig_out}` equals `op_a + op_b + inc`, where inc is the rounding increment chosen by R3 to R6. When inc is 0 the value is exactly `op_a + op_b`.
- R2: With `eff_sub`=1 and `op_a >= op_b`, `{carry_out, sig_out}` equals `op_a - op_b + inc`. The increment is taken from the X+2 candidate, with no second adder.
- R3: Mode code 2'b00 (nearest, ties to even) increments only when the guard bit is 1 and either the truncated LSB is 1 or round OR sticky is 1.
- R4: Mode code 2'b01 (toward zero) never increments.
- R5: Mode code 2'b10 (toward +infinity) increments when `res_neg`=0 and any of guard, round or sticky is 1, and never when `res_neg`=1.
- R6: Mode code 2'b11 (toward -infinity) increments when `res_neg`=1 and any of guard, round or sticky is 1, and never when `res_neg`=0.
- R7: `inexact` equals guard OR round OR sticky.
- R8: When the rounded value reaches 2^SIG_W, `carry_out` is 1 and `sig_out` holds the low SIG_W bits. This includes the case where the increment ripples out of an all-ones truncated value.
- R9: All outputs are registered with a latency of one clock. A synchronous active-low reset clears them to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | SIG_W | First aligned significand (larger one when subtracting) |
| op_b | input | SIG_W | Second aligned significand |
| eff_sub | input | 1 | 1 = effective subtraction, 0 = effective addition |
| res_neg | input | 1 | Sign of the result, 1 = negative |
| grd | input | 1 | Guard bit below the result LSB |
| rnd | input | 1 | Round bit below the guard bit |
| stk | input | 1 | Sticky bit, OR of all lower bits |
| rmode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| sig_out | output | SIG_W | Rounded significand |
| carry_out | output | 1 | Rounded value overflowed SIG_W bits; renormalize |
| inexact | output | 1 | Any discarded bit was nonzero |

## Verification
Two functions can meet in a single cycle: the rounding increment and the renormalization carry. This happens when the truncated value is all ones and the mode, sign and guard/round/sticky bits call for an increment. The increment then ripples out as `carry_out` with a zero significand. The bench provokes this case for addition under nearest-even. It provokes it for subtraction under toward -infinity, where the X+2 candidate is selected. It also covers an addition whose truncated sum already carries and is then incremented. In each case the carry and the significand are judged together against the exact value of the operand sum or difference plus one.

// File: rtl/sig_round_pkg.sv
// Package: shared types for the significand rounding unit.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sig_round_pkg;

    // Rounding-mode codes; the numeric values are decoded at the port.
    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_TO_POS    = 2'b10,
        RM_TO_NEG    = 2'b11
    } rmode_e;

endpackage

// File: rtl/sig_compound_add.sv
// Module: sig_compound_add
// Forms X = A + B' (B' = B or ~B) once, then X+1 and X+2 with parallel
// trailing-ones prefix chains instead of further carry-propagate adders.
// Assumes: all outputs are W+2 bits wide so X+2 never wraps.
module sig_compound_add #(
    parameter int W = 24
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W+1:0] sum0_o,
    output logic [W+1:0] sum1_o,
    output logic [W+1:0] sum2_o
);
    localparam int XW = W + 2;

    logic [W-1:0]  b_sel;
    logic [XW-1:0] x;
    logic [XW-1:0] all1_lo;   // all1_lo[i]: bits x[i-1:0] are all ones
    logic [XW-1:1] all1_hi;   // all1_hi[i]: bits x[i-1:1] are all ones

    // Select true or inverted second operand and form the base sum.
    always_comb begin
        b_sel = sub_i ? ~b_i : b_i;
        x     = {2'b00, a_i} + {2'b00, b_sel};
    end

    assign all1_lo[0] = 1'b1;
    assign all1_hi[1] = 1'b1;

    // Prefix chains: a bit toggles under +1 (or +2) when all lower bits are ones.
    for (genvar i = 0; i < XW - 1; i++) begin : g_lo
        assign all1_lo[i+1] = all1_lo[i] & x[i];
    end
    for (genvar i = 1; i < XW - 1; i++) begin : g_hi
        assign all1_hi[i+1] = all1_hi[i] & x[i];
    end

    // Candidate bits from the toggle masks.
    for (genvar i = 0; i < XW; i++) begin : g_out
        assign sum0_o[i] = x[i];
        assign sum1_o[i] = x[i] ^ all1_lo[i];
        if (i == 0) begin : g_b0
            assign sum2_o[i] = x[i];
        end else begin : g_bn
            assign sum2_o[i] = x[i] ^ all1_hi[i];
        end
    end

endmodule

// File: rtl/sig_round_decide.sv
// Module: sig_round_decide
// Decides whether the truncated result is incremented, from mode, sign,
// truncated LSB and guard/round/sticky. Also flags inexactness.
// Assumes: guard/round/sticky describe the exact fraction below the LSB.
module sig_round_decide
    import sig_round_pkg::*;
(
    input  logic [1:0] rmode_i,
    input  logic       neg_i,
    input  logic       lsb_i,
    input  logic       grd_i,
    input  logic       rnd_i,
    input  logic       stk_i,
    output logic       inc_o,
    output logic       inexact_o
);
    logic any_lost;

    // Increment decision per mode.
    always_comb begin
        any_lost = grd_i | rnd_i | stk_i;
        unique case (rmode_e'(rmode_i))
            RM_NEAR_EVEN: inc_o = grd_i & (lsb_i | rnd_i | stk_i);
            RM_TO_ZERO:   inc_o = 1'b0;
            RM_TO_POS:    inc_o = ~neg_i & any_lost;
            RM_TO_NEG:    inc_o = neg_i & any_lost;
            default:      inc_o = 1'b0;
        endcase
        inexact_o = any_lost;
    end

endmodule

// File: rtl/sig_cand_select.sv
// Module: sig_cand_select
// Picks the truncated and incremented candidates for the operation
// (add: X and X+1, subtract: X+1 and X+2), then the final one by inc.
// Assumes: for subtraction A >= B, so X+1 already equals A-B + 2^W.
module sig_cand_select #(
    parameter int W = 24
) (
    input  logic [W+1:0] sum0_i,
    input  logic [W+1:0] sum1_i,
    input  logic [W+1:0] sum2_i,
    input  logic         sub_i,
    input  logic         inc_i,
    output logic         lsb_o,
    output logic [W-1:0] sig_o,
    output logic         carry_o
);
    logic [W+1:0] base;
    logic [W+1:0] bump;
    logic [W+1:0] pick;

    // Candidate pair for the operation, then the rounding choice.
    always_comb begin
        base    = sub_i ? sum1_i : sum0_i;
        bump    = sub_i ? sum2_i : sum1_i;
        lsb_o   = base[0];
        pick    = inc_i ? bump : base;
        sig_o   = pick[W-1:0];
        carry_o = sub_i ? pick[W+1] : pick[W];
    end

endmodule

// File: rtl/sig_round_unit.sv
// Module: sig_round_unit (top)
// Add/subtract-and-round of aligned significands with registered outputs.
// Assumes: op_a >= op_b when eff_sub=1; grd/rnd/stk supplied by caller.
module sig_round_unit #(
    parameter int SIG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SIG_W-1:0] op_a,
    input  logic [SIG_W-1:0] op_b,
    input  logic             eff_sub,
    input  logic             res_neg,
    input  logic             grd,
    input  logic             rnd,
    input  logic             stk,
    input  logic [1:0]       rmode,
    output logic [SIG_W-1:0] sig_out,
    output logic             carry_out,
    output logic             inexact
);
    logic [SIG_W+1:0] s0, s1, s2;
    logic             base_lsb;
    logic             do_inc;
    logic             inx_c;
    logic [SIG_W-1:0] sig_c;
    logic             carry_c;

    sig_compound_add #(.W(SIG_W)) u_add (
        .a_i    (op_a),
        .b_i    (op_b),
        .sub_i  (eff_sub),
        .sum0_o (s0),
        .sum1_o (s1),
        .sum2_o (s2)
    );

    sig_round_decide u_dec (
        .rmode_i   (rmode),
        .neg_i     (res_neg),
        .lsb_i     (base_lsb),
        .grd_i     (grd),
        .rnd_i     (rnd),
        .stk_i     (stk),
        .inc_o     (do_inc),
        .inexact_o (inx_c)
    );

    sig_cand_select #(.W(SIG_W)) u_sel (
        .sum0_i  (s0),
        .sum1_i  (s1),
        .sum2_i  (s2),
        .sub_i   (eff_sub),
        .inc_i   (do_inc),
        .lsb_o   (base_lsb),
        .sig_o   (sig_c),
        .carry_o (carry_c)
    );

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_out   <= '0;
            carry_out <= 1'b0;
            inexact   <= 1'b0;
        end else begin
            sig_out   <= sig_c;
            carry_out <= carry_c;
            inexact   <= inx_c;
        end
    end

endmodule

// File: rtl/sig_round_unit_chk.sv
// Module: sig_round_unit_chk
// Property checker for sig_round_unit, attached by bind below.
module sig_round_unit_chk #(
    parameter int SIG_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SIG_W-1:0] op_a,
    input logic [SIG_W-1:0] op_b,
    input logic             eff_sub,
    input logic             grd,
    input logic             rnd,
    input logic             stk,
    input logic [1:0]       rmode,
    input logic [SIG_W-1:0] sig_out,
    input logic             carry_out,
    input logic             inexact
);
    localparam int VW = SIG_W + 1;

    // R4: toward-zero addition yields exactly the operand sum.
    a_r4_tz_add_exact: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rmode) == 2'b01 && !$past(eff_sub))
        |-> ({carry_out, sig_out} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)})));

    // R2: toward-zero subtraction yields exactly the difference.
    a_r2_tz_sub_exact: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rmode) == 2'b01 && $past(eff_sub) && $past(op_a) >= $past(op_b))
        |-> ({carry_out, sig_out} == ({1'b0, $past(op_a)} - {1'b0, $past(op_b)})));

    // R1: an addition result is the sum or the sum plus one.
    a_r1_add_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(eff_sub))
        |-> (VW'({carry_out, sig_out} - ({1'b0, $past(op_a)} + {1'b0, $past(op_b)})) <= VW'(1)));

    // R7: inexact follows the discarded bits.
    a_r7_inexact: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (inexact == ($past(grd) | $past(rnd) | $past(stk))));

    // R9: a reset cycle leaves all outputs at zero.
    a_r9_reset_clear: assert property (@(posedge clk)
        (!$past(rst_n)) |-> (sig_out == '0 && !carry_out && !inexact));

endmodule

bind sig_round_unit sig_round_unit_chk #(.SIG_W(SIG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_a      (op_a),
    .op_b      (op_b),
    .eff_sub   (eff_sub),
    .grd       (grd),
    .rnd       (rnd),
    .stk       (stk),
    .rmode     (rmode),
    .sig_out   (sig_out),
    .carry_out (carry_out),
    .inexact   (inexact)
);

// File: tb/tb_sig_round_unit.sv
// Bench for sig_round_unit at SIG_W=8: vector table, then reset checks.
module tb_sig_round_unit;
    localparam int  W        = 8;
    localparam time CLK_PER  = 10ns;
    localparam int  NVEC     = 18;

    // Vector: a[32:25] b[24:17] sub[16] neg[15] grs[14:12] mode[11:10]
    //         exp_carry[9] exp_sig[8:1] exp_inexact[0]
    localparam logic [32:0] VEC [NVEC] = '{
        {8'h12, 8'h34, 1'b0, 1'b0, 3'b000, 2'd0, 1'b0, 8'h46, 1'b0}, // R1 plain add
        {8'h80, 8'h80, 1'b0, 1'b0, 3'b000, 2'd1, 1'b1, 8'h00, 1'b0}, // R1 R8 add carry
        {8'h50, 8'h20, 1'b1, 1'b0, 3'b000, 2'd0, 1'b0, 8'h30, 1'b0}, // R2 sub
        {8'h05, 8'h05, 1'b1, 1'b0, 3'b000, 2'd0, 1'b0, 8'h00, 1'b0}, // R2 equal sub
        {8'h10, 8'h02, 1'b0, 1'b0, 3'b100, 2'd0, 1'b0, 8'h12, 1'b1}, // R3 tie even
        {8'h10, 8'h03, 1'b0, 1'b0, 3'b100, 2'd0, 1'b0, 8'h14, 1'b1}, // R3 tie odd
        {8'h10, 8'h02, 1'b0, 1'b0, 3'b101, 2'd0, 1'b0, 8'h13, 1'b1}, // R3 above half
        {8'h10, 8'h03, 1'b0, 1'b0, 3'b011, 2'd0, 1'b0, 8'h13, 1'b1}, // R3 below half
        {8'h10, 8'h03, 1'b0, 1'b0, 3'b111, 2'd1, 1'b0, 8'h13, 1'b1}, // R4 truncate
        {8'h10, 8'h02, 1'b0, 1'b0, 3'b001, 2'd2, 1'b0, 8'h13, 1'b1}, // R5 pos up
        {8'h10, 8'h02, 1'b0, 1'b1, 3'b111, 2'd2, 1'b0, 8'h12, 1'b1}, // R5 neg trunc
        {8'h10, 8'h02, 1'b0, 1'b1, 3'b001, 2'd3, 1'b0, 8'h13, 1'b1}, // R6 neg up
        {8'h10, 8'h02, 1'b0, 1'b0, 3'b100, 2'd3, 1'b0, 8'h12, 1'b1}, // R6 pos trunc
        {8'h40, 8'h11, 1'b1, 1'b0, 3'b001, 2'd2, 1'b0, 8'h30, 1'b1}, // R2 R5 sub +1
        {8'hF0, 8'h0F, 1'b0, 1'b0, 3'b110, 2'd0, 1'b1, 8'h00, 1'b1}, // R8 add ripple
        {8'hFF, 8'h00, 1'b1, 1'b1, 3'b100, 2'd3, 1'b1, 8'h00, 1'b1}, // R8 sub ripple
        {8'hFF, 8'hFF, 1'b0, 1'b0, 3'b001, 2'd2, 1'b1, 8'hFF, 1'b1}, // R8 carry+inc
        {8'h09, 8'h02, 1'b1, 1'b0, 3'b100, 2'd0, 1'b0, 8'h08, 1'b1}  // R3 sub tie odd
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] op_a, op_b;
    logic         eff_sub, res_neg, grd, rnd, stk;
    logic [1:0]   rmode;
    logic [W-1:0] sig_out;
    logic         carry_out, inexact;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done     = 1'b0;

    always #(CLK_PER / 2) clk = ~clk;

    sig_round_unit #(.SIG_W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_a      (op_a),
        .op_b      (op_b),
        .eff_sub   (eff_sub),
        .res_neg   (res_neg),
        .grd       (grd),
        .rnd       (rnd),
        .stk       (stk),
        .rmode     (rmode),
        .sig_out   (sig_out),
        .carry_out (carry_out),
        .inexact   (inexact)
    );

    // Compare all three outputs against one expected triple.
    task automatic check(input string req, input logic ec, input logic [W-1:0] es,
                         input logic ei);
        n_checks++;
        if (carry_out !== ec || sig_out !== es || inexact !== ei) begin
            n_errors++;
            $display("FAIL %s: got carry=%0b sig=%02h inexact=%0b, expected carry=%0b sig=%02h inexact=%0b",
                     req, carry_out, sig_out, inexact, ec, es, ei);
        end
    endtask

    // Apply one input set at a falling edge.
    task automatic drive(input logic [32:0] v);
        op_a    = v[32:25];
        op_b    = v[24:17];
        eff_sub = v[16];
        res_neg = v[15];
        {grd, rnd, stk} = v[14:12];
        rmode   = v[11:10];
    endtask

    initial begin
        rst_n = 1'b0;
        drive({8'hFF, 8'h01, 1'b0, 1'b0, 3'b111, 2'd0, 1'b0, 8'h00, 1'b0});
        repeat (3) @(negedge clk);
        check("R9 reset state", 1'b0, 8'h00, 1'b0);
        rst_n = 1'b1;

        // Table walk: drive at negedge, result registered at next posedge.
        for (int k = 0; k < NVEC; k++) begin
            drive(VEC[k]);
            @(negedge clk);
            check($sformatf("vector %0d (R1..R8 per table)", k), VEC[k][9], VEC[k][8:1], VEC[k][0]);
        end

        // R9: one-cycle latency; output holds until the edge after a change.
        drive({8'h01, 8'h01, 1'b0, 1'b0, 3'b000, 2'd0, 1'b0, 8'h00, 1'b0});
        @(negedge clk);
        check("R9 latency new value", 1'b0, 8'h02, 1'b0);
        drive({8'h03, 8'h01, 1'b0, 1'b0, 3'b000, 2'd0, 1'b0, 8'h00, 1'b0});
        @(posedge clk);
        #1;
        check("R9 registered after edge", 1'b0, 8'h04, 1'b0);

        // R9: synchronous reset mid-run clears outputs.
        @(negedge clk);
        drive({8'hF0, 8'h0F, 1'b0, 1'b0, 3'b110, 2'd0, 1'b0, 8'h00, 1'b0});
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid-run reset", 1'b0, 8'h00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset release", 1'b1, 8'h00, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PER * 5000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule